// File: doc/BRIEF.md
# Binary Clock Timer with Coherent Nibble Readout

This block is a timekeeping peripheral that sits on a narrow 4-bit register bus. It counts a 256 Hz single-cycle tick into an 8-bit binary value. Bit 0 toggles at 128 Hz, and each higher bit toggles at half the rate of the bit below it, so bit 7 toggles once per second. Software controls the count with a run bit that freezes and resumes it, a write-only clear strobe, and a tick-gate bit that stops all ticks from reaching the counter to save power.

Software reads the 8-bit count as two nibbles. A read of the low nibble also captures the upper nibble into a holding register. The upper-nibble address always returns that held copy and never the live count. A read of the low nibble followed by a read of the high nibble therefore gives a consistent pair, even if a carry crosses the nibble boundary between the two reads.

Register map (3-bit address):

| Address | Contents |
|---|---|
| 0 | control register |
| 1 | tick-gate register |
| 2 | low nibble of the count |
| 3 | latched high nibble of the count |
| 4 to 7 | unused |

Top module: `bin_clock_timer`

## Requirements
- R1: After synchronous reset, the count, the run bit, the tick-gate bit, the high-nibble latch and `bus_rdata_o` are all 0.
- R2: The count goes up by exactly one on each cycle where `tick_i` is 1 and both the run bit and the tick-gate bit are 1. The count is a plain binary value, so bit i of the count toggles at (128 >> i) Hz.
- R3: The count holds its value on any cycle where `tick_i`, the run bit or the tick-gate bit is 0. A held count continues from its held value once all three are 1 again.
- R4: Writing the control register (address 0) with data bit 1 set clears the count to 00h. This happens whatever the run state, and it overrides a tick in the same cycle. Writing the control register with data bit 1 clear never clears the count.
- R5: The control register holds the run bit in data bit 0, and a read returns it there. Data bit 1 always reads as 0. The tick-gate register (address 1) holds its enable in data bit 0, and a read returns it there. All other bits of both registers read as 0.
- R6: A read of address 2 returns count bits [3:0]. In the same cycle, count bits [7:4] are copied into the high-nibble latch. Both values are taken from the count as it stood before that clock edge.
- R7: A read of address 3 returns the high-nibble latch, not the live count. The latch changes only when address 2 is read.
- R8: Writes to address 2 or address 3 change neither the count nor the latch.
- R9: Read data is registered, so it appears on the cycle after the read strobe. `bus_rdata_o` is 0 after any cycle with no read strobe. It is also 0 after a read of an unused address (4 to 7).
- R10: When the count is FFh, an advancing tick takes it to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| tick_i | input | 1 | 256 Hz single-cycle tick |
| bus_addr_i | input | 3 | register address |
| bus_rd_i | input | 1 | read strobe |
| bus_wr_i | input | 1 | write strobe |
| bus_wdata_i | input | 4 | write data |
| bus_rdata_o | output | 4 | registered read data |

## Verification
The bound checker tests the counter on every cycle. It checks that the count steps by exactly one when it should (wraparound included) and holds its value otherwise. It checks that a clear strobe leaves 00h in the next cycle, even when a tick arrives in the same cycle. It checks that the high-nibble latch moves only on a low-nibble read and then holds the pre-edge upper bits, that idle cycles return zero data, and that the clear bit never reads back as set. The bench scenarios cover what a single-cycle property cannot. These are the resumption of a frozen count across stop and start, and a coherent two-access read while a carry crosses the nibble boundary. They also include the long run to the FFh-to-00h wrap, and the absence of any effect from writes to the read-only data addresses.

// File: rtl/bct_pkg.sv
package bct_pkg;

    localparam int unsigned BCT_ADDR_W = 3;

    localparam logic [BCT_ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [BCT_ADDR_W-1:0] ADDR_GATE = 3'd1;
    localparam logic [BCT_ADDR_W-1:0] ADDR_LO   = 3'd2;
    localparam logic [BCT_ADDR_W-1:0] ADDR_HI   = 3'd3;

    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_CLR_BIT = 1;
    localparam int unsigned GATE_EN_BIT  = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_GATE,
        SEL_LO,
        SEL_HI
    } rd_sel_e;

    typedef struct packed {
        logic run;
        logic gate_en;
    } ctl_t;

    function automatic rd_sel_e decode_rd(input logic [BCT_ADDR_W-1:0] a);
        rd_sel_e s;
        case (a)
            ADDR_CTRL: s = SEL_CTRL;
            ADDR_GATE: s = SEL_GATE;
            ADDR_LO:   s = SEL_LO;
            ADDR_HI:   s = SEL_HI;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bct_bus_regs.sv
module bct_bus_regs
    import bct_pkg::*;
#(
    parameter int unsigned DATA_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_i,
    input  logic                  wr_i,
    input  logic [BCT_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output ctl_t                  ctl_o,
    output logic                  clr_o,
    output rd_sel_e               rd_sel_o
);

    ctl_t ctl_q;
    logic ctl_wr;
    logic gate_wr;

    assign ctl_wr  = wr_i && (addr_i == ADDR_CTRL);
    assign gate_wr = wr_i && (addr_i == ADDR_GATE);

    // The clear is a strobe: it is never stored as state.
    assign clr_o    = ctl_wr && wdata_i[CTRL_CLR_BIT];
    assign rd_sel_o = rd_i ? decode_rd(addr_i) : SEL_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            if (ctl_wr)  ctl_q.run     <= wdata_i[CTRL_RUN_BIT];
            if (gate_wr) ctl_q.gate_en <= wdata_i[GATE_EN_BIT];
        end
    end

    assign ctl_o = ctl_q;

    logic unused_wbits;
    assign unused_wbits = ^wdata_i[DATA_W-1:2];

endmodule

// File: rtl/bct_counter.sv
module bct_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   carry;

    assign carry[0] = adv_i;

    // One divide-by-two stage per bit. A stage toggles when every lower
    // stage is 1 and the chain advances.
    for (genvar i = 0; i < CNT_W; i++) begin : g_stage
        assign carry[i+1] = carry[i] & cnt_q[i];
        always_ff @(posedge clk) begin
            if (rst || clr_i) cnt_q[i] <= 1'b0;
            else if (carry[i]) cnt_q[i] <= ~cnt_q[i];
        end
    end

    assign count_o = cnt_q;

    logic unused_carry;
    assign unused_carry = carry[CNT_W];

endmodule

// File: rtl/bct_readout.sv
module bct_readout
    import bct_pkg::*;
#(
    parameter int unsigned DATA_W = 4,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  rd_sel_e            sel_i,
    input  logic [CNT_W-1:0]   count_i,
    input  ctl_t               ctl_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [DATA_W-1:0]  hi_lat_o
);

    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        case (sel_i)
            SEL_CTRL: rd_mux[CTRL_RUN_BIT] = ctl_i.run;
            SEL_GATE: rd_mux[GATE_EN_BIT]  = ctl_i.gate_en;
            SEL_LO:   rd_mux = count_i[DATA_W-1:0];
            SEL_HI:   rd_mux = hi_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_mux;
            if (sel_i == SEL_LO) hi_q <= count_i[CNT_W-1:DATA_W];
        end
    end

    assign rdata_o  = rdata_q;
    assign hi_lat_o = hi_q;

endmodule

// File: rtl/bin_clock_timer.sv
module bin_clock_timer
    import bct_pkg::*;
#(
    parameter int unsigned DATA_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_i,
    input  logic [BCT_ADDR_W-1:0] bus_addr_i,
    input  logic                  bus_rd_i,
    input  logic                  bus_wr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    output logic [DATA_W-1:0]     bus_rdata_o
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    ctl_t             ctl_w;
    logic             clr_w;
    rd_sel_e          sel_w;
    logic             adv_w;
    logic [CNT_W-1:0] count_w;
    logic [DATA_W-1:0] hi_lat_w;

    bct_bus_regs #(.DATA_W(DATA_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .rd_i     (bus_rd_i),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .ctl_o    (ctl_w),
        .clr_o    (clr_w),
        .rd_sel_o (sel_w)
    );

    assign adv_w = tick_i & ctl_w.run & ctl_w.gate_en;

    bct_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (adv_w),
        .clr_i   (clr_w),
        .count_o (count_w)
    );

    bct_readout #(.DATA_W(DATA_W)) rdo_i (
        .clk      (clk),
        .rst      (rst),
        .sel_i    (sel_w),
        .count_i  (count_w),
        .ctl_i    (ctl_w),
        .rdata_o  (bus_rdata_o),
        .hi_lat_o (hi_lat_w)
    );

endmodule

// File: rtl/bct_checker.sv
module bct_checker
    import bct_pkg::*;
#(
    parameter int unsigned DATA_W = 4,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tick,
    input logic                  rd,
    input logic                  wr,
    input logic [BCT_ADDR_W-1:0] addr,
    input logic [DATA_W-1:0]     wdata,
    input logic [DATA_W-1:0]     rdata,
    input logic [CNT_W-1:0]      count,
    input logic [DATA_W-1:0]     hi_lat,
    input logic                  run,
    input logic                  gate_en
);

    logic clr_req;
    logic adv_req;
    assign clr_req = wr && (addr == ADDR_CTRL) && wdata[CTRL_CLR_BIT];
    assign adv_req = tick && run && gate_en;

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> (count == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (adv_req && !clr_req) |=> (count == CNT_W'($past(count) + CNT_W'(1))));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!adv_req && !clr_req) |=> $stable(count));

    assert_latch_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == ADDR_LO) |=> (hi_lat == $past(count[CNT_W-1:DATA_W])));

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(rd && addr == ADDR_LO) |=> $stable(hi_lat));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (rdata == '0));

    assert_clr_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == ADDR_CTRL) |=> (rdata[CTRL_CLR_BIT] == 1'b0));

endmodule

bind bin_clock_timer bct_checker #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_i),
    .rd      (bus_rd_i),
    .wr      (bus_wr_i),
    .addr    (bus_addr_i),
    .wdata   (bus_wdata_i),
    .rdata   (bus_rdata_o),
    .count   (count_w),
    .hi_lat  (hi_lat_w),
    .run     (ctl_w.run),
    .gate_en (ctl_w.gate_en)
);

// File: tb/bin_clock_timer_tb_top.sv
module bin_clock_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic [2:0] bus_addr_i = '0;
    logic       bus_rd_i = 1'b0;
    logic       bus_wr_i = 1'b0;
    logic [3:0] bus_wdata_i = '0;
    logic [3:0] bus_rdata_o;

    always #10 clk = ~clk;   // 50 MHz

    bin_clock_timer dut_i (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .bus_addr_i  (bus_addr_i),
        .bus_rd_i    (bus_rd_i),
        .bus_wr_i    (bus_wr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o)
    );

    int checks = 0;
    int fails  = 0;

    // reference model
    logic [7:0] m_cnt = '0;
    logic       m_run = 1'b0;
    logic       m_en  = 1'b0;
    logic [3:0] m_lat = '0;

    function automatic logic [3:0] model_read(input logic [2:0] a);
        case (a)
            3'd0:    return {3'b000, m_run};
            3'd1:    return {3'b000, m_en};
            3'd2:    return m_cnt[3:0];
            3'd3:    return m_lat;
            default: return 4'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic rd, input logic [2:0] a);
        if (!rd) return "R9";
        case (a)
            3'd0, 3'd1: return "R5";
            3'd2:       return "R6";
            3'd3:       return "R7";
            default:    return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: rdata=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive one bus cycle at a falling edge, update the model, check after the edge.
    task automatic step(input logic tk, input logic rd, input logic wr,
                        input logic [2:0] a, input logic [3:0] d, input string tag);
        logic [3:0] exp;
        logic clr;
        logic adv;
        tick_i = tk; bus_rd_i = rd; bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = d;
        exp = rd ? model_read(a) : 4'h0;
        if (rd && a == 3'd2) m_lat = m_cnt[7:4];
        clr = wr && (a == 3'd0) && d[1];
        adv = tk && m_run && m_en;
        if (clr) m_cnt = '0;
        else if (adv) m_cnt = m_cnt + 8'd1;
        if (wr && a == 3'd0) m_run = d[0];
        if (wr && a == 3'd1) m_en = d[0];
        @(posedge clk);
        @(negedge clk);
        check(tag, bus_rdata_o, exp);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [3:0] d, input string tag);
        step(1'b0, 1'b0, 1'b1, a, d, tag);
    endtask

    task automatic rd_reg(input logic [2:0] a, input string tag);
        step(1'b0, 1'b1, 1'b0, a, 4'h0, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 3'd0, 4'h0, tag);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'hC10C);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1", bus_rdata_o, 4'h0);
        rd_reg(3'd2, "R1");
        rd_reg(3'd3, "R1");
        rd_reg(3'd0, "R1");
        rd_reg(3'd1, "R1");

        // R8: writes to data addresses ignored
        wr_reg(3'd2, 4'hF, "R8");
        wr_reg(3'd3, 4'hF, "R8");
        rd_reg(3'd2, "R8");
        rd_reg(3'd3, "R8");

        // R2: counting with gate and run on
        wr_reg(3'd1, 4'h1, "R5");
        wr_reg(3'd0, 4'h1, "R5");
        rd_reg(3'd0, "R5");
        rd_reg(3'd1, "R5");
        ticks(5, "R2");
        rd_reg(3'd2, "R2");

        // R3: stop holds, resume continues, gate off holds
        wr_reg(3'd0, 4'h0, "R3");
        ticks(4, "R3");
        rd_reg(3'd2, "R3");
        wr_reg(3'd0, 4'h1, "R3");
        ticks(3, "R3");
        rd_reg(3'd2, "R3");
        wr_reg(3'd1, 4'h0, "R3");
        ticks(6, "R3");
        rd_reg(3'd2, "R3");
        wr_reg(3'd1, 4'h1, "R3");

        // R4: clear while running beats a simultaneous tick; bit1 clear does nothing
        step(1'b1, 1'b0, 1'b1, 3'd0, 4'h3, "R4");
        rd_reg(3'd2, "R4");
        rd_reg(3'd3, "R4");
        ticks(2, "R4");
        wr_reg(3'd0, 4'h1, "R4");
        rd_reg(3'd2, "R4");
        rd_reg(3'd0, "R4");

        // R6/R7: latch across a nibble carry
        ticks(13, "R6");           // count = 0x0F
        rd_reg(3'd2, "R6");        // latch 0
        ticks(1, "R7");            // count = 0x10
        rd_reg(3'd3, "R7");        // still latched 0
        rd_reg(3'd2, "R6");        // latch 1
        rd_reg(3'd3, "R7");

        // R10: wrap past FFh
        ticks(250, "R10");
        rd_reg(3'd2, "R10");
        rd_reg(3'd3, "R10");
        ticks(20, "R10");
        rd_reg(3'd2, "R10");
        rd_reg(3'd3, "R10");

        // R9: unused addresses read zero
        rd_reg(3'd5, "R9");
        rd_reg(3'd7, "R9");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned op;
            logic [2:0] a;
            logic [3:0] d;
            logic tk;
            op = $urandom_range(0, 9);
            a  = 3'($urandom_range(0, 7));
            d  = 4'($urandom_range(0, 15));
            if (a == 3'd0 && $urandom_range(0, 7) != 0) d[1] = 1'b0;
            if (a == 3'd0 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
            if (a == 3'd1 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
            tk = ($urandom_range(0, 2) != 0);
            if (op < 5)      step(tk, 1'b1, 1'b0, a, 4'h0, tag_for(1'b1, a));
            else if (op < 6) step(tk, 1'b0, 1'b1, a, d, "R9");
            else             step(tk, 1'b0, 1'b0, a, 4'h0, "R9");
        end

        summary();
        $finish;
    end

endmodule